// File: doc/BRIEF.md
# Command-Driven Register Access Controller

This block places a small sequencer in front of an eight-entry, byte-wide register file. A host raises a start strobe together with a 4-bit command and a 3-bit register address. The sequencer decodes the command while it is idle. A write command starts a receive handshake. The sequencer waits for the receive valid line to rise and then to fall. It then raises its internal write enable for exactly one cycle, and the byte on the receive data input is stored in the addressed register. A read command starts a transmit handshake. The addressed register appears on the read output with the transmit valid flag set. That data is held until the host's acknowledge rises and then falls again.

When a cycle finishes, a one-cycle done pulse is raised and the sequencer returns to idle. All eight register values are also exposed on a flat output bus, so surrounding logic can use them as control bits. The register address is latched when a cycle starts. A host may therefore change the address input during a handshake without effect.

Top module: `regacc_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero and puts the sequencer in idle: tx_valid_o and done_o are low.
- R2: In idle, command 4'b1100 starts a write cycle and command 4'b1101 starts a read cycle. A cycle starts only on a clock edge where start_i is high. A defined command presented with start_i low starts nothing.
- R3: A write cycle waits for rx_valid_i to be high and then for it to be low. The write enable is then active for exactly one cycle, and the register is loaded with rx_data_i as sampled at the clock edge that ends that cycle. A bench driving rx_valid_i high then low, one cycle each, therefore sees the register updated three clock edges after the starting edge.
- R4: A register changes only during the write-enable cycle, and only when it is the latched target. All other registers keep their values.
- R5: One clock edge after a read cycle starts, tx_valid_o goes high with rd_data_o showing the addressed register. It stays high until tx_ack_i has been seen high and then low, and it falls on the edge that samples tx_ack_i low.
- R6: rd_data_o always shows the register selected by the latched address. regs_o carries register k at bits [8k+7:8k].
- R7: done_o is high for exactly one cycle: the first idle cycle after a write or read cycle completes. It is never high while a handshake is in progress.
- R8: The register address is captured from addr_i on the edge that starts a cycle. Changes on addr_i after that edge affect neither the written register nor the read data.
- R9: Any command value other than 4'b1100 and 4'b1101 leaves the sequencer idle, even with start_i high. No register changes, and neither tx_valid_o nor done_o is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe that allows the idle sequencer to accept a command |
| cmd_i | input | 4 | Command code: 1100 write, 1101 read |
| addr_i | input | 3 | Target register address, latched when a cycle starts |
| rx_data_i | input | 8 | Byte to be written |
| rx_valid_i | input | 1 | Receive handshake valid from the host |
| tx_ack_i | input | 1 | Transmit handshake acknowledge from the host |
| tx_valid_o | output | 1 | Read data is valid on rd_data_o |
| rd_data_o | output | 8 | Register selected by the latched address |
| regs_o | output | 64 | All eight registers, register k at bits [8k+7:8k] |
| done_o | output | 1 | One-cycle pulse when a write or read cycle completes |

## Verification
Several properties are checked on every cycle. The write enable lasts a single cycle and starts only after receive valid has been sampled low. A register that is not being written holds its value, and a register that is written takes the data on the write edge. The latched address cannot move outside idle. Transmit valid survives an acknowledge. Done is a lone pulse issued from idle. An undefined or unstrobed command keeps the sequencer idle. Only the directed scenarios can show the rest. These cover the exact edge on which a write or a read completes, the read value matching earlier writes, a prolonged receive valid delaying the write, and address changes during a handshake having no effect.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WR_HI  = 3'd1,
    ST_WR_LO  = 3'd2,
    ST_WR_STB = 3'd3,
    ST_RD_HI  = 3'd4,
    ST_RD_LO  = 3'd5
  } regacc_state_e;
endpackage

// File: rtl/regacc_regfile.sv
module regacc_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [DATA_W-1:0]                rd_data,
  output logic [(DATA_W<<ADDR_W)-1:0]      regs_flat
);
  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0]   wsel;
  logic [DATA_W-1:0] mem [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign wsel[k] = (addr == ADDR_W'(k));

    always_ff @(posedge clk) begin
      if (rst)                   mem[k] <= '0;
      else if (wr_en && wsel[k]) mem[k] <= wr_data;
    end

    assign regs_flat[k*DATA_W +: DATA_W] = mem[k];

    // R4: an unselected or unenabled entry keeps its value
    assert_reg_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wsel[k]) |=> $stable(mem[k]));
    // R3: a selected entry takes the write data on the enable edge
    assert_reg_load_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wsel[k]) |=> (mem[k] == $past(wr_data)));
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/regacc_seq.sv
module regacc_seq
  import regacc_pkg::*;
#(
  parameter int                ADDR_W = 3,
  parameter int                CMD_W  = 4,
  parameter logic [CMD_W-1:0]  CMD_WR = 4'b1100,
  parameter logic [CMD_W-1:0]  CMD_RD = 4'b1101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rx_valid,
  input  logic              tx_ack,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_en,
  output logic              tx_valid,
  output logic              done
);
  regacc_state_e state_q, state_d;
  logic go_wr, go_rd, finish;

  assign go_wr = start && (cmd == CMD_WR);
  assign go_rd = start && (cmd == CMD_RD);

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (go_wr) state_d = ST_WR_HI;
                 else if (go_rd) state_d = ST_RD_HI;
      ST_WR_HI:  if (rx_valid) state_d = ST_WR_LO;
      ST_WR_LO:  if (!rx_valid) state_d = ST_WR_STB;
      ST_WR_STB: begin state_d = ST_IDLE; finish = 1'b1; end
      ST_RD_HI:  if (tx_ack) state_d = ST_RD_LO;
      ST_RD_LO:  if (!tx_ack) begin state_d = ST_IDLE; finish = 1'b1; end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= finish;
      if (state_q == ST_IDLE && (go_wr || go_rd)) addr_q <= addr_in;
    end
  end

  assign wr_en    = (state_q == ST_WR_STB);
  assign tx_valid = (state_q == ST_RD_HI) || (state_q == ST_RD_LO);

  // R3: write enable lasts one cycle
  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  // R3: write enable only follows a sampled-low receive valid
  assert_we_after_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> !$past(rx_valid));
  // R5: an acknowledge never drops valid in the same step
  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ack) |=> tx_valid);
  // R7: done is a lone pulse issued while idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!tx_valid && !wr_en));
  // R8: latched address is frozen during a cycle
  assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(addr_q));
  // R2 / R9: no strobe or an unknown command keeps the sequencer idle
  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !go_wr && !go_rd) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/regacc_ctrl.sv
module regacc_ctrl #(
  parameter int                DATA_W = 8,
  parameter int                ADDR_W = 3,
  parameter int                CMD_W  = 4,
  parameter logic [CMD_W-1:0]  CMD_WR = 4'b1100,
  parameter logic [CMD_W-1:0]  CMD_RD = 4'b1101
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [CMD_W-1:0]            cmd_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           rx_data_i,
  input  logic                        rx_valid_i,
  input  logic                        tx_ack_i,
  output logic                        tx_valid_o,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [(DATA_W<<ADDR_W)-1:0] regs_o,
  output logic                        done_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              wr_en;

  regacc_seq #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start_i), .cmd(cmd_i), .addr_in(addr_i),
    .rx_valid(rx_valid_i), .tx_ack(tx_ack_i), .addr_q(addr_q),
    .wr_en(wr_en), .tx_valid(tx_valid_o), .done(done_o)
  );

  regacc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rf_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr_q),
    .wr_data(rx_data_i), .rd_data(rd_data_o), .regs_flat(regs_o)
  );
endmodule

// File: tb/regacc_ctrl_tb_top.sv
module regacc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [3:0]  cmd_i;
  logic [2:0]  addr_i;
  logic [7:0]  rx_data_i;
  logic        rx_valid_i;
  logic        tx_ack_i;
  logic        tx_valid_o;
  logic [7:0]  rd_data_o;
  logic [63:0] regs_o;
  logic        done_o;

  int pass_cnt = 0;
  int tot_cnt  = 0;
  logic [7:0] model [8];

  always #4 clk = ~clk;

  regacc_ctrl dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i), .addr_i(addr_i),
    .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i), .tx_ack_i(tx_ack_i),
    .tx_valid_o(tx_valid_o), .rd_data_o(rd_data_o), .regs_o(regs_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tot_cnt++;
    if (ok) pass_cnt++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_all_regs(input string req);
    for (int k = 0; k < 8; k++)
      chk(regs_o[k*8 +: 8] == model[k], req, regs_o[k*8 +: 8], model[k]);
  endtask

  task automatic t_reset;
    rst = 1'b1; start_i = 0; cmd_i = 0; addr_i = 0; rx_data_i = 0;
    rx_valid_i = 0; tx_ack_i = 0;
    tick(3);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    tick(1);
    chk(regs_o == 64'h0, "R1 regs cleared", regs_o, 64'h0);
    chk(!tx_valid_o && !done_o, "R1 idle outputs", {tx_valid_o, done_o}, 0);
  endtask

  // write with optional extra cycles of rx_valid and an address change mid-cycle
  task automatic t_write(input logic [2:0] a, input logic [7:0] d,
                         input int hold, input bit move_addr);
    start_i = 1; cmd_i = 4'b1100; addr_i = a; rx_data_i = d;
    tick(1);
    start_i = 0;
    if (move_addr) addr_i = a + 3'd1;
    rx_valid_i = 1;
    tick(1 + hold);
    chk(regs_o[a*8 +: 8] == model[a], "R3 no write while valid high",
        regs_o[a*8 +: 8], model[a]);
    chk(!done_o, "R7 no done mid-write", done_o, 0);
    rx_valid_i = 0;
    tick(1);
    chk(regs_o[a*8 +: 8] == model[a], "R3 not yet written", regs_o[a*8 +: 8], model[a]);
    tick(1);
    model[a] = d;
    chk(done_o, "R7 done after write", done_o, 1);
    chk_all_regs(move_addr ? "R8 write target latched" : "R4 only target written");
    tick(1);
    chk(!done_o, "R7 done single cycle", done_o, 0);
  endtask

  task automatic t_read(input logic [2:0] a, input int wait_ack, input bit move_addr);
    start_i = 1; cmd_i = 4'b1101; addr_i = a;
    tick(1);
    start_i = 0;
    if (move_addr) addr_i = a + 3'd2;
    chk(tx_valid_o, "R5 valid raised", tx_valid_o, 1);
    chk(rd_data_o == model[a], move_addr ? "R8 read addr latched" : "R6 read data",
        rd_data_o, model[a]);
    tick(wait_ack);
    chk(tx_valid_o && rd_data_o == model[a], "R5 held until ack",
        {tx_valid_o, rd_data_o}, {1'b1, model[a]});
    tx_ack_i = 1;
    tick(2);
    chk(tx_valid_o && !done_o, "R5 held while ack high", {tx_valid_o, done_o}, 2'b10);
    tx_ack_i = 0;
    tick(1);
    chk(!tx_valid_o, "R5 valid dropped", tx_valid_o, 0);
    chk(done_o, "R7 done after read", done_o, 1);
    tick(1);
    chk(!done_o, "R7 done single cycle read", done_o, 0);
  endtask

  // undefined command or missing strobe: nothing may happen
  task automatic t_ignored(input logic [3:0] c, input bit strobe, input string req);
    start_i = strobe; cmd_i = c; addr_i = 3'd6; rx_data_i = 8'hEE;
    tick(1);
    start_i = 0;
    rx_valid_i = 1; tick(1); rx_valid_i = 0;
    tx_ack_i = 1; tick(1); tx_ack_i = 0;
    for (int i = 0; i < 4; i++) begin
      chk(!tx_valid_o && !done_o, req, {tx_valid_o, done_o}, 0);
      tick(1);
    end
    chk_all_regs(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tot_cnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", pass_cnt, tot_cnt);
    $finish;
  end

  initial begin
    t_reset();
    t_write(3'd2, 8'hA5, 0, 0);
    t_write(3'd7, 8'h3C, 3, 0);
    t_write(3'd0, 8'h81, 0, 1);
    t_write(3'd2, 8'h5A, 1, 0);
    t_read(3'd2, 0, 0);
    t_read(3'd7, 4, 0);
    t_read(3'd0, 1, 1);
    t_read(3'd5, 0, 0);
    t_ignored(4'b0000, 1'b1, "R9 cmd 0000 ignored");
    t_ignored(4'b1110, 1'b1, "R9 cmd 1110 ignored");
    t_ignored(4'b1100, 1'b0, "R2 write needs start");
    t_ignored(4'b1101, 1'b0, "R2 read needs start");
    t_write(3'd6, 8'hFF, 0, 0);
    t_read(3'd6, 0, 0);
    chk(regs_o[6*8 +: 8] == 8'hFF, "R6 regs_o slice", regs_o[6*8 +: 8], 8'hFF);
    $display("%0d/%0d checks passed", pass_cnt, tot_cnt);
    $finish;
  end
endmodule